// File: doc/BRIEF.md
# Audio Sample Rate Detector

This block times the incoming audio word-select (frame) clock against a free-running reference clock. It resolves the frame rate to one of nine standard audio rates and keeps a small rate register that a downstream clock divider reads. The reference clock is assumed to sit somewhere between 13.3 MHz and 17 MHz, and its nominal frequency is a parameter. Rate windows are computed from that nominal value at elaboration time.

Two strap pins pick the operating mode. They also supply a two-bit sub-address that is passed to the control interface. In the fully automatic mode the rate register always follows the detector and host writes do nothing. In the three standard modes the register starts at 48 kHz and follows the detector only while the detected rate is 32 kHz or above. A host write with a legal code loads the register and freezes it until the next reset.

Top module: `sample_rate_detector`

## Requirements
- R1: Rate codes are 4 bits wide and numbered in ascending rate order: 0 = 8000 Hz, 1 = 11025 Hz, 2 = 12000 Hz, 3 = 16000 Hz, 4 = 22050 Hz, 5 = 24000 Hz, 6 = 32000 Hz, 7 = 44100 Hz, 8 = 48000 Hz. While `rate_valid` is high, `rate_code` holds a value from 0 to 8.
- R2: One measurement counts reference cycles across 2^FRAMES_LOG2 whole frame periods. The periods are bounded by rising edges of `ws_in`, taken after a two-flop synchroniser. A count matches rate i when it is within (nominal count × TOL_PPM / 10^6 + MARGIN) counts of that rate's nominal count.
- R3: A word-select running at any of the nine rates, at its nominal frequency or offset by ±200 ppm, is classified with the correct code.
- R4: `rate_valid` rises only when two consecutive measurements give the same code. A measurement that differs from the one before it clears `rate_valid`.
- R5: A measurement that fits no window clears `rate_valid`. In that case `rate_code` and `rate_reg` keep their previous values.
- R6: If no synchronised rising edge of `ws_in` arrives within 2^TIMEOUT_LOG2 reference cycles during a measurement, `rate_valid` is cleared.
- R7: `sub_addr` equals the value on `mode_sel`, registered. `mode_sel` = 3 selects the fully automatic mode.
- R8: When `mode_sel` = 3, `rate_reg` loads `rate_code` on every cycle in which `rate_valid` is high. Host writes have no effect on it.
- R9: When `mode_sel` is 0, 1 or 2 and no host write has occurred since reset, `rate_reg` loads a valid `rate_code` only if the code is 6 to 8. Otherwise it keeps its value.
- R10: When `mode_sel` is 0, 1 or 2, a host write with `host_data` from 0 to 8 loads `rate_reg` on the next cycle and stops any further automatic updates until reset. A host write with `host_data` from 9 to 15 is ignored.
- R11: Synchronous reset sets `rate_valid` = 0, `rate_code` = 0, `rate_reg` = 8 and `sub_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_in | input | 1 | Asynchronous audio word-select (frame clock) |
| mode_sel | input | 2 | Strap pins: 0..2 standard, 3 fully automatic |
| host_wr | input | 1 | Host write strobe for the rate register |
| host_data | input | 4 | Rate code written by the host |
| rate_code | output | 4 | Last confirmed detected rate code |
| rate_valid | output | 1 | Detected rate confirmed and current |
| rate_reg | output | 4 | Effective rate register driving the divider |
| sub_addr | output | 2 | Device sub-address taken from the strap pins |

## Verification
The bench sweeps all nine rates at nominal frequency and at both ±200 ppm offsets. A window that is too narrow, or two neighbouring windows that are confused, would show up as a wrong code or a missing valid flag. It checks that valid stays low after the first measurement following reset, which catches a design that trusts a single count. It also feeds an unlisted 40 kHz rate and then stops the frame clock entirely; a detector without a reject path or a timeout would keep reporting a stale rate. The rate register is compared every cycle against a behavioural model across host writes, including an out-of-range code, writes in the fully automatic mode, and low rates in standard mode. A design with the wrong write priority, a missing lock, or sub-32 kHz tracking therefore diverges on the first cycle it goes wrong.

// File: rtl/srd_pkg.sv
`timescale 1ns/1ps
package srd_pkg;
  localparam int NUM_RATES = 9;
  localparam int CODE_W    = 4;
  localparam logic [CODE_W-1:0] CODE_MAX   = 4'd8;
  localparam logic [CODE_W-1:0] CODE_32K   = 4'd6;
  localparam logic [1:0]        MODE_AUTO  = 2'b11;

  function automatic longint rate_hz(input int idx);
    case (idx)
      0: return 64'd8000;
      1: return 64'd11025;
      2: return 64'd12000;
      3: return 64'd16000;
      4: return 64'd22050;
      5: return 64'd24000;
      6: return 64'd32000;
      7: return 64'd44100;
      default: return 64'd48000;
    endcase
  endfunction

  // Rounded count of reference cycles over 2^lg frames at rate idx
  function automatic longint nom_count(input longint ref_hz, input int lg, input int idx);
    longint num;
    num = ref_hz * (longint'(1) << lg);
    return (num + rate_hz(idx) / 2) / rate_hz(idx);
  endfunction

  function automatic longint tol_count(input longint n, input int ppm, input int margin);
    return (n * ppm) / 1000000 + longint'(margin);
  endfunction
endpackage

// File: rtl/srd_edge_sync.sv
`timescale 1ns/1ps
module srd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rise_o <= 1'b0;
    end else begin
      sh_q   <= {sh_q[1:0], async_in};
      rise_o <= sh_q[1] & ~sh_q[2];
    end
  end
endmodule

// File: rtl/srd_period_counter.sv
`timescale 1ns/1ps
module srd_period_counter #(
  parameter int FRAMES_LOG2  = 8,
  parameter int TIMEOUT_LOG2 = 20,
  parameter int CW           = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edge_i,
  output logic          meas_done,
  output logic [CW-1:0] meas_count,
  output logic          timeout
);
  logic                    armed_q;
  logic [FRAMES_LOG2-1:0]  frame_q;
  logic [CW-1:0]           cnt_q;
  logic [TIMEOUT_LOG2-1:0] idle_q;
  logic [CW-1:0]           cnt_inc;

  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      frame_q    <= '0;
      cnt_q      <= '0;
      idle_q     <= '0;
      meas_done  <= 1'b0;
      meas_count <= '0;
      timeout    <= 1'b0;
    end else begin
      meas_done <= 1'b0;
      timeout   <= 1'b0;
      if (!armed_q) begin
        if (edge_i) begin
          armed_q <= 1'b1;
          frame_q <= '0;
          cnt_q   <= '0;
          idle_q  <= '0;
        end
      end else if (edge_i) begin
        idle_q  <= '0;
        frame_q <= frame_q + 1'b1;
        if (frame_q == '1) begin
          meas_done  <= 1'b1;
          meas_count <= cnt_inc;
          cnt_q      <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end else if (idle_q == '1) begin
        timeout <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
        cnt_q  <= cnt_inc;
      end
    end
  end

  // R6
  done_vs_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    meas_done |-> !timeout);

  // R2
  count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    meas_done |-> (meas_count != '0));
endmodule

// File: rtl/srd_classifier.sv
`timescale 1ns/1ps
module srd_classifier
  import srd_pkg::*;
#(
  parameter longint REF_HZ      = 14_725_000,
  parameter int     FRAMES_LOG2 = 8,
  parameter int     TOL_PPM     = 200,
  parameter int     MARGIN      = 2,
  parameter int     CW          = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_done_i,
  input  logic [CW-1:0]     meas_count_i,
  input  logic              timeout_i,
  output logic              valid_q,
  output logic [CODE_W-1:0] code_q
);
  logic [NUM_RATES-1:0] hit;
  logic                 match;
  logic [CODE_W-1:0]    enc;
  logic [CODE_W-1:0]    prev_q;
  logic                 have_prev_q;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_win
    localparam longint NOM = nom_count(REF_HZ, FRAMES_LOG2, i);
    localparam longint TOL = tol_count(NOM, TOL_PPM, MARGIN);
    localparam logic [CW-1:0] LO = CW'(NOM - TOL);
    localparam logic [CW-1:0] HI = CW'(NOM + TOL);
    assign hit[i] = (meas_count_i >= LO) && (meas_count_i <= HI);
  end

  assign match = |hit;

  always_comb begin
    enc = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (hit[i]) enc = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      code_q      <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (timeout_i) begin
      valid_q     <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (meas_done_i) begin
      if (!match) begin
        valid_q     <= 1'b0;
        have_prev_q <= 1'b0;
      end else begin
        if (have_prev_q && (prev_q == enc)) begin
          valid_q <= 1'b1;
          code_q  <= enc;
        end else begin
          valid_q <= 1'b0;
        end
        prev_q      <= enc;
        have_prev_q <= 1'b1;
      end
    end
  end

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (code_q <= CODE_MAX));

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(meas_done_i));

  // R6
  timeout_clear_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_i |=> !valid_q);
endmodule

// File: rtl/srd_rate_reg.sv
`timescale 1ns/1ps
module srd_rate_reg
  import srd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              host_wr,
  input  logic [CODE_W-1:0] host_data,
  input  logic              det_valid,
  input  logic [CODE_W-1:0] det_code,
  output logic [CODE_W-1:0] rate_q,
  output logic [1:0]        sub_q
);
  logic auto_mode;
  logic lock_q;
  logic host_ok;

  assign auto_mode = (mode_sel == MODE_AUTO);
  assign host_ok   = host_wr && (host_data <= CODE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= CODE_MAX;
      lock_q <= 1'b0;
      sub_q  <= '0;
    end else begin
      sub_q <= mode_sel;
      if (auto_mode) begin
        if (det_valid) rate_q <= det_code;
      end else if (host_ok) begin
        rate_q <= host_data;
        lock_q <= 1'b1;
      end else if (!lock_q && det_valid && (det_code >= CODE_32K)) begin
        rate_q <= det_code;
      end
    end
  end

  // R7
  sub_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (sub_q == $past(mode_sel)));

  // R8
  auto_host_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_mode && !det_valid) |=> $stable(rate_q));

  // R9
  low_rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && !host_wr && det_valid && (det_code < CODE_32K)) |=> $stable(rate_q));

  // R10
  host_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && host_wr && (host_data <= CODE_MAX)) |=> (rate_q == $past(host_data)));
endmodule

// File: rtl/sample_rate_detector.sv
`timescale 1ns/1ps
module sample_rate_detector
  import srd_pkg::*;
#(
  parameter longint REF_HZ       = 14_725_000,
  parameter int     FRAMES_LOG2  = 8,
  parameter int     TIMEOUT_LOG2 = 20,
  parameter int     TOL_PPM      = 200,
  parameter int     MARGIN       = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ws_in,
  input  logic [1:0]  mode_sel,
  input  logic        host_wr,
  input  logic [3:0]  host_data,
  output logic [3:0]  rate_code,
  output logic        rate_valid,
  output logic [3:0]  rate_reg,
  output logic [1:0]  sub_addr
);
  localparam longint MAX_NOM = nom_count(REF_HZ, FRAMES_LOG2, 0);
  localparam longint MAX_HI  = MAX_NOM + tol_count(MAX_NOM, TOL_PPM, MARGIN);
  localparam int     CW      = $clog2(MAX_HI + 1) + 1;

  logic          ws_rise;
  logic          meas_done;
  logic [CW-1:0] meas_count;
  logic          timeout;

  srd_edge_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ws_in),
    .rise_o   (ws_rise)
  );

  srd_period_counter #(
    .FRAMES_LOG2  (FRAMES_LOG2),
    .TIMEOUT_LOG2 (TIMEOUT_LOG2),
    .CW           (CW)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (ws_rise),
    .meas_done  (meas_done),
    .meas_count (meas_count),
    .timeout    (timeout)
  );

  srd_classifier #(
    .REF_HZ      (REF_HZ),
    .FRAMES_LOG2 (FRAMES_LOG2),
    .TOL_PPM     (TOL_PPM),
    .MARGIN      (MARGIN),
    .CW          (CW)
  ) u_cls (
    .clk          (clk),
    .rst          (rst),
    .meas_done_i  (meas_done),
    .meas_count_i (meas_count),
    .timeout_i    (timeout),
    .valid_q      (rate_valid),
    .code_q       (rate_code)
  );

  srd_rate_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .host_wr   (host_wr),
    .host_data (host_data),
    .det_valid (rate_valid),
    .det_code  (rate_code),
    .rate_q    (rate_reg),
    .sub_q     (sub_addr)
  );

  // R5
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rate_valid) |-> $stable(rate_code));
endmodule

// File: tb/sample_rate_detector_tb.sv
`timescale 1ns/1ps
module sample_rate_detector_tb;
  localparam longint REF_HZ = 1_472_500;
  localparam int FL = 2;
  localparam int TL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ws = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic host_wr = 1'b0;
  logic [3:0] host_data = 4'd0;
  logic [3:0] rate_code;
  logic rate_valid;
  logic [3:0] rate_reg;
  logic [1:0] sub_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit ws_on = 1'b0;
  real ws_half = 100.0;
  bit model_on = 1'b0;
  bit done = 1'b0;
  int m_reg = 8;
  int m_sub = 0;
  bit m_lock = 1'b0;

  always #5 clk = ~clk;

  sample_rate_detector #(
    .REF_HZ(REF_HZ), .FRAMES_LOG2(FL), .TIMEOUT_LOG2(TL)
  ) u_dut (
    .clk(clk), .rst(rst), .ws_in(ws), .mode_sel(mode_sel),
    .host_wr(host_wr), .host_data(host_data),
    .rate_code(rate_code), .rate_valid(rate_valid),
    .rate_reg(rate_reg), .sub_addr(sub_addr)
  );

  initial begin
    forever begin
      if (ws_on) begin
        ws = 1'b1; #(ws_half);
        ws = 1'b0; #(ws_half);
      end else begin
        ws = 1'b0; #10.0;
      end
    end
  end

  function automatic int hz(input int idx);
    case (idx)
      0: return 8000;  1: return 11025; 2: return 12000;
      3: return 16000; 4: return 22050; 5: return 24000;
      6: return 32000; 7: return 44100; default: return 48000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-cycle behavioural model of rate register and sub-address (R7..R11)
  always @(negedge clk) begin
    if (model_on) begin
      chk(int'(rate_reg) == m_reg, "R8/R9/R10 rate_reg model", int'(rate_reg), m_reg);
      chk(int'(sub_addr) == m_sub, "R7 sub_addr model", int'(sub_addr), m_sub);
    end
    if (rst) begin
      m_reg = 8; m_sub = 0; m_lock = 1'b0;
    end else begin
      m_sub = int'(mode_sel);
      if (mode_sel == 2'd3) begin
        if (rate_valid) m_reg = int'(rate_code);
      end else if (host_wr && host_data <= 4'd8) begin
        m_reg = int'(host_data); m_lock = 1'b1;
      end else if (!m_lock && rate_valid && rate_code >= 4'd6) begin
        m_reg = int'(rate_code);
      end
    end
  end

  function automatic int meas_cycles(input int fs);
    return int'((longint'(1) << FL) * REF_HZ / fs) + 1;
  endfunction

  task automatic set_ws(input int fs, input int ppm);
    ws_half = 10.0 * real'(REF_HZ) / (real'(fs) * (1.0 + real'(ppm) * 1.0e-6)) / 2.0;
    ws_on = 1'b1;
  endtask

  task automatic settle(input int fs);
    repeat (5 * meas_cycles(fs) + 20) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [3:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_data = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(posedge clk); #1;
    ws_on = 1'b0; rst = 1'b1; mode_sel = m;
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    model_on = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rate_valid == 1'b0, "R11 valid at reset", int'(rate_valid), 0);
    chk(rate_code == 4'd0, "R11 code at reset", int'(rate_code), 0);
    chk(rate_reg == 4'd8, "R11 rate_reg at reset", int'(rate_reg), 8);
    chk(sub_addr == 2'd0, "R11 sub_addr at reset", int'(sub_addr), 0);
    @(posedge clk); #1; rst = 1'b0;

    // R4: one measurement is not enough
    set_ws(48000, 0);
    repeat (meas_cycles(48000) * 3 / 2 + 10) @(posedge clk);
    @(negedge clk);
    chk(rate_valid == 1'b0, "R4 valid after single measurement", int'(rate_valid), 0);
    repeat (meas_cycles(48000)) @(posedge clk);
    @(negedge clk);
    chk(rate_valid == 1'b1, "R4 valid after two matching measurements", int'(rate_valid), 1);

    // R1/R3/R9: sweep all rates at nominal and +/-200 ppm in standard mode 0
    for (int idx = 0; idx < 9; idx++) begin
      for (int v = 0; v < 3; v++) begin
        int ppm;
        ppm = (v == 0) ? 0 : ((v == 1) ? 200 : -200);
        set_ws(hz(idx), ppm);
        settle(hz(idx));
        chk(rate_code == 4'(idx), "R3 detected code", int'(rate_code), idx);
        chk(rate_valid == 1'b1, "R1 valid for listed rate", int'(rate_valid), 1);
      end
      chk(int'(rate_reg) == ((idx >= 6) ? idx : 8), "R9 default tracking",
          int'(rate_reg), (idx >= 6) ? idx : 8);
    end

    // R5: unlisted 40 kHz rejected, code and register held
    set_ws(40000, 0);
    settle(40000);
    chk(rate_valid == 1'b0, "R5 unmatched rate clears valid", int'(rate_valid), 0);
    chk(rate_code == 4'd8, "R5 code held", int'(rate_code), 8);
    chk(rate_reg == 4'd8, "R5 rate_reg held", int'(rate_reg), 8);

    // R6: word-select stops
    set_ws(48000, 0);
    settle(48000);
    chk(rate_valid == 1'b1, "R6 valid before stop", int'(rate_valid), 1);
    ws_on = 1'b0;
    repeat ((1 << TL) + 200) @(posedge clk);
    @(negedge clk);
    chk(rate_valid == 1'b0, "R6 timeout clears valid", int'(rate_valid), 0);
    chk(rate_code == 4'd8, "R6 code held after timeout", int'(rate_code), 8);

    // R10: host override in standard mode
    set_ws(16000, 0);
    settle(16000);
    chk(rate_code == 4'd3 && rate_valid, "R9 16k detected", int'(rate_code), 3);
    chk(rate_reg == 4'd8, "R9 low rate not tracked", int'(rate_reg), 8);
    host_write(4'd2);
    chk(rate_reg == 4'd2, "R10 host write loads", int'(rate_reg), 2);
    host_write(4'd9);
    chk(rate_reg == 4'd2, "R10 out-of-range write ignored", int'(rate_reg), 2);
    set_ws(48000, 0);
    settle(48000);
    chk(rate_code == 4'd8, "R10 48k detected while locked", int'(rate_code), 8);
    chk(rate_reg == 4'd2, "R10 lock holds register", int'(rate_reg), 2);

    // R7/R8: fully automatic mode
    do_reset(2'd3);
    @(negedge clk);
    chk(sub_addr == 2'd3, "R7 sub_addr mode 3", int'(sub_addr), 3);
    set_ws(16000, 0);
    settle(16000);
    chk(rate_reg == 4'd3, "R8 auto mode follows low rate", int'(rate_reg), 3);
    host_write(4'd7);
    repeat (3) @(negedge clk);
    chk(rate_reg == 4'd3, "R8 host write ignored in auto mode", int'(rate_reg), 3);
    set_ws(24000, 0);
    settle(24000);
    chk(rate_reg == 4'd5, "R8 auto mode follows new rate", int'(rate_reg), 5);

    // R7: remaining strap codes
    for (int m = 1; m < 3; m++) begin
      do_reset(2'(m));
      @(negedge clk);
      chk(int'(sub_addr) == m, "R7 sub_addr strap", int'(sub_addr), m);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule